// File: doc/BRIEF.md
# Single-Outstanding DMA Request Controller

This block sits between a local DMA sequencer and the memory directories of a chip. The sequencer presents load or store requests on a valid/ready input. The controller accepts one request at a time and turns it into a directory read or write message. That message carries the address, the data block, the transfer length and a directory number computed from the address. A fixed-length shift pipeline delays each message before it reaches the directory port. The controller then waits on an in-order response channel for the single reply that completes the transaction.

A state machine with three states drives all of this. `ST_READY` takes new work. `ST_BUSY_RD` waits for a data reply, and `ST_BUSY_WR` waits for a write acknowledgement. The transitions are:
- **accept-load**: `ST_READY` to `ST_BUSY_RD`.
- **accept-store**: `ST_READY` to `ST_BUSY_WR`.
- **data-return**: `ST_BUSY_RD` to `ST_READY`.
- **ack-return**: `ST_BUSY_WR` to `ST_READY`.

Every other event leaves the state where it is. An illegal request code, an illegal response code, or a response that does not fit the pending transaction sets a sticky error flag. Only reset clears that flag.

Top module: `dma_req_ctrl`

## Requirements
- R1: After reset the controller is in ST_READY with req_ready high and dir_valid, rd_valid, wr_done and err_flag all low.
- R2: In ST_READY, a request with req_kind 2'b00 (load) is consumed and issues a message with dir_kind 0 (read). A request with req_kind 2'b01 (store) is consumed and issues a message with dir_kind 1 (write). In both cases dir_addr, dir_data and dir_len equal the request's address, data and length.
- R3: A request accepted on clock edge k is presented on the directory port with dir_valid high for exactly one cycle, sampled on edge k+ISSUE_DELAY (default 6).
- R4: dir_dest equals (req_addr >> LINE_OFF) modulo NUM_DIRS (defaults: LINE_OFF 6, NUM_DIRS 4).
- R5: While the controller is in ST_BUSY_RD or ST_BUSY_WR, req_ready is low. A waiting request is not consumed, issues no message, and is accepted unchanged once the controller is ready again.
- R6: In ST_BUSY_RD, a response with rsp_kind 2'b10 (data) raises rd_valid for one cycle with rd_data equal to rsp_data, and returns the controller to ST_READY.
- R7: In ST_BUSY_WR, a response with rsp_kind 2'b01 (ack) raises wr_done for one cycle and returns the controller to ST_READY.
- R8: With rd_valid or wr_done, cpl_addr equals rsp_addr with its low LINE_OFF bits cleared.
- R9: A response that does not fit the state leaves the state unchanged, produces no completion pulse and sets err_flag. This covers ack in ST_BUSY_RD, data in ST_BUSY_WR, and any response in ST_READY.
- R10: In ST_READY, a request with req_kind 2'b10 or 2'b11 is consumed without issuing any message, sets err_flag, and leaves the controller in ST_READY.
- R11: A response with rsp_kind 2'b00 or 2'b11 sets err_flag and changes no state.
- R12: Once set, err_flag stays high until reset.
- R13: req_ready is low while an issued message is still inside the delay pipeline, even if the controller has already returned to ST_READY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Sequencer request present |
| req_ready | output | 1 | Request consumed on this edge when valid |
| req_kind | input | 2 | 00 load, 01 store, others illegal |
| req_addr | input | ADDR_W | Physical address |
| req_data | input | DATA_W | Data block |
| req_len | input | LEN_W | Transfer length |
| dir_valid | output | 1 | Directory message present (one cycle) |
| dir_kind | output | 1 | 0 read, 1 write |
| dir_dest | output | DEST_W | Target directory number |
| dir_addr | output | ADDR_W | Message address |
| dir_data | output | DATA_W | Message data block |
| dir_len | output | LEN_W | Message length |
| rsp_valid | input | 1 | Response present, consumed in the same cycle |
| rsp_kind | input | 2 | 01 ack, 10 data, others illegal |
| rsp_addr | input | ADDR_W | Response address |
| rsp_data | input | DATA_W | Response data block |
| rd_valid | output | 1 | Read data return pulse |
| rd_data | output | DATA_W | Returned data block |
| wr_done | output | 1 | Write completion pulse |
| cpl_addr | output | ADDR_W | Line-aligned address of the completion |
| err_flag | output | 1 | Sticky protocol error |

## Verification
A request that is accepted on edge k appears on the directory port only on edge k+ISSUE_DELAY. The bench therefore steps one falling edge at a time after acceptance and expects dir_valid low at every step except the (ISSUE_DELAY-1)-th falling edge after k. Completion pulses, the line-aligned address and err_flag are all registered, so they are due one edge after the response or request is consumed. The bench samples them at the falling edge that follows, and checks again one cycle later that each pulse has dropped. Stall and pipeline-occupancy effects show up only as req_ready, so the bench reads req_ready at each falling edge of the window where it should stay low.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

    typedef enum logic [1:0] {
        ST_READY   = 2'd0,
        ST_BUSY_RD = 2'd1,
        ST_BUSY_WR = 2'd2
    } dma_state_e;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_BAD   = 2'd2
    } req_op_e;

    typedef enum logic [1:0] {
        RSP_ACK  = 2'd0,
        RSP_DATA = 2'd1,
        RSP_BAD  = 2'd2
    } rsp_op_e;

    localparam logic [1:0] REQ_CODE_LOAD  = 2'b00;
    localparam logic [1:0] REQ_CODE_STORE = 2'b01;
    localparam logic [1:0] RSP_CODE_ACK   = 2'b01;
    localparam logic [1:0] RSP_CODE_DATA  = 2'b10;

endpackage

// File: rtl/dma_req_decode.sv
module dma_req_decode
    import dma_req_pkg::*;
(
    input  logic [1:0] req_kind,
    input  logic [1:0] rsp_kind,
    output req_op_e    req_op,
    output rsp_op_e    rsp_op
);

    always_comb begin
        unique case (req_kind)
            REQ_CODE_LOAD:  req_op = OP_LOAD;
            REQ_CODE_STORE: req_op = OP_STORE;
            default:        req_op = OP_BAD;
        endcase
    end

    always_comb begin
        unique case (rsp_kind)
            RSP_CODE_ACK:  rsp_op = RSP_ACK;
            RSP_CODE_DATA: rsp_op = RSP_DATA;
            default:       rsp_op = RSP_BAD;
        endcase
    end

endmodule

// File: rtl/dma_dir_map.sv
module dma_dir_map #(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFF = 6,
    parameter int NUM_DIRS = 4,
    parameter int DEST_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DEST_W-1:0] dest
);

    generate
        if (NUM_DIRS == 1) begin : g_single
            assign dest = '0;
        end else begin : g_multi
            logic [ADDR_W-1:0] line_idx;
            logic [ADDR_W-1:0] dir_mod;
            assign line_idx = addr >> LINE_OFF;
            assign dir_mod  = line_idx % ADDR_W'(NUM_DIRS);
            assign dest     = dir_mod[DEST_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/dma_issue_pipe.sv
module dma_issue_pipe #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_data,
    output logic             out_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             empty
);

    logic [DEPTH-1:0] vld_q;
    logic [WIDTH-1:0] dat_q [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (!rst_n) vld_q[0] <= 1'b0;
                    else        vld_q[0] <= in_valid;
                    dat_q[0] <= in_data;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (!rst_n) vld_q[i] <= 1'b0;
                    else        vld_q[i] <= vld_q[i-1];
                    dat_q[i] <= dat_q[i-1];
                end
            end
        end
    endgenerate

    assign out_valid = vld_q[DEPTH-1];
    assign out_data  = dat_q[DEPTH-1];
    assign empty     = ~|vld_q;

endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl
    import dma_req_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int LEN_W       = 8,
    parameter int LINE_OFF    = 6,
    parameter int NUM_DIRS    = 4,
    parameter int ISSUE_DELAY = 6,
    parameter int DEST_W      = (NUM_DIRS > 1) ? $clog2(NUM_DIRS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [LEN_W-1:0]  req_len,
    output logic              dir_valid,
    output logic              dir_kind,
    output logic [DEST_W-1:0] dir_dest,
    output logic [ADDR_W-1:0] dir_addr,
    output logic [DATA_W-1:0] dir_data,
    output logic [LEN_W-1:0]  dir_len,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_kind,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_done,
    output logic [ADDR_W-1:0] cpl_addr,
    output logic              err_flag
);

    localparam int MSG_W = 1 + DEST_W + LEN_W + DATA_W + ADDR_W;
    localparam logic [ADDR_W-1:0] LINE_MASK =
        ~((ADDR_W'(1) << LINE_OFF) - ADDR_W'(1));

    dma_state_e state_q, state_d;
    req_op_e    req_op;
    rsp_op_e    rsp_op;
    logic [DEST_W-1:0] req_dest;
    logic [MSG_W-1:0]  msg_in, msg_out;
    logic pipe_empty;
    logic accept, issue, req_bad;
    logic rsp_rd_ok, rsp_wr_ok, rsp_bad;

    dma_req_decode u_decode (
        .req_kind (req_kind),
        .rsp_kind (rsp_kind),
        .req_op   (req_op),
        .rsp_op   (rsp_op)
    );

    dma_dir_map #(
        .ADDR_W   (ADDR_W),
        .LINE_OFF (LINE_OFF),
        .NUM_DIRS (NUM_DIRS),
        .DEST_W   (DEST_W)
    ) u_dir_map (
        .addr (req_addr),
        .dest (req_dest)
    );

    // Handshake and event decode
    assign req_ready = (state_q == ST_READY) && pipe_empty;
    assign accept    = req_valid && req_ready;
    assign issue     = accept && (req_op != OP_BAD);
    assign req_bad   = accept && (req_op == OP_BAD);
    assign rsp_rd_ok = rsp_valid && (state_q == ST_BUSY_RD) && (rsp_op == RSP_DATA);
    assign rsp_wr_ok = rsp_valid && (state_q == ST_BUSY_WR) && (rsp_op == RSP_ACK);
    assign rsp_bad   = rsp_valid && !rsp_rd_ok && !rsp_wr_ok;

    assign msg_in = {(req_op == OP_STORE), req_dest, req_len, req_data, req_addr};

    dma_issue_pipe #(
        .WIDTH (MSG_W),
        .DEPTH (ISSUE_DELAY)
    ) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (issue),
        .in_data   (msg_in),
        .out_valid (dir_valid),
        .out_data  (msg_out),
        .empty     (pipe_empty)
    );

    assign {dir_kind, dir_dest, dir_len, dir_data, dir_addr} = msg_out;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (issue) state_d = (req_op == OP_LOAD) ? ST_BUSY_RD : ST_BUSY_WR;
            end
            ST_BUSY_RD: begin
                if (rsp_rd_ok) state_d = ST_READY;
            end
            ST_BUSY_WR: begin
                if (rsp_wr_ok) state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            wr_done  <= 1'b0;
            err_flag <= 1'b0;
            rd_data  <= '0;
            cpl_addr <= '0;
        end else begin
            rd_valid <= rsp_rd_ok;
            wr_done  <= rsp_wr_ok;
            err_flag <= err_flag | req_bad | rsp_bad;
            if (rsp_rd_ok) rd_data <= rsp_data;
            if (rsp_rd_ok || rsp_wr_ok) cpl_addr <= rsp_addr & LINE_MASK;
        end
    end

endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk
    import dma_req_pkg::*;
#(
    parameter int NUM_DIRS = 4,
    parameter int DEST_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input dma_state_e        state_q,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic              dir_valid,
    input logic [DEST_W-1:0] dir_dest,
    input logic              rsp_valid,
    input logic [1:0]        rsp_kind,
    input logic              rd_valid,
    input logic              wr_done,
    input logic              err_flag
);

    a_r2_load_to_busy_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'b00) |=> state_q == ST_BUSY_RD);

    a_r2_store_to_busy_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'b01) |=> state_q == ST_BUSY_WR);

    a_r3_dir_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dir_valid |=> !dir_valid);

    a_r4_dest_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        dir_valid |-> (32'(dir_dest) < NUM_DIRS));

    a_r5_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_READY) |-> !req_ready);

    a_r6_rd_from_busy_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(state_q) == ST_BUSY_RD);

    a_r7_wr_from_busy_wr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> $past(state_q) == ST_BUSY_WR);

    a_r9_ack_in_rd_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && state_q == ST_BUSY_RD && rsp_kind == 2'b01) |=> (state_q == ST_BUSY_RD && err_flag));

    a_r9_data_in_wr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && state_q == ST_BUSY_WR && rsp_kind == 2'b10) |=> (state_q == ST_BUSY_WR && err_flag));

    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

endmodule

bind dma_req_ctrl dma_req_ctrl_chk #(
    .NUM_DIRS (NUM_DIRS),
    .DEST_W   (DEST_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_q   (state_q),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_kind  (req_kind),
    .dir_valid (dir_valid),
    .dir_dest  (dir_dest),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .rd_valid  (rd_valid),
    .wr_done   (wr_done),
    .err_flag  (err_flag)
);

// File: tb/dma_req_ctrl_tb.sv
module dma_req_ctrl_tb;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 64;
    localparam int LEN_W  = 8;
    localparam int LOFF   = 6;
    localparam int NDIR   = 4;
    localparam int DLY    = 6;
    localparam int DW     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_kind = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic dir_valid, dir_kind;
    logic [DW-1:0] dir_dest;
    logic [ADDR_W-1:0] dir_addr;
    logic [DATA_W-1:0] dir_data;
    logic [LEN_W-1:0] dir_len;
    logic rsp_valid = 1'b0;
    logic [1:0] rsp_kind = '0;
    logic [ADDR_W-1:0] rsp_addr = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic rd_valid, wr_done, err_flag;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] cpl_addr;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    dma_req_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W), .LINE_OFF(LOFF),
        .NUM_DIRS(NDIR), .ISSUE_DELAY(DLY)
    ) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
        .dir_valid(dir_valid), .dir_kind(dir_kind), .dir_dest(dir_dest),
        .dir_addr(dir_addr), .dir_data(dir_data), .dir_len(dir_len),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_addr(rsp_addr),
        .rsp_data(rsp_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .wr_done(wr_done), .cpl_addr(cpl_addr), .err_flag(err_flag)
    );

    typedef struct packed {
        logic [1:0]        kind;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] raddr;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{2'b00, 32'h0000_1040, 64'h0123_4567_89ab_cdef, 8'd64, 32'h0000_1047},
        '{2'b01, 32'h0000_20c0, 64'hfeed_face_cafe_beef, 8'd32, 32'h0000_20ff},
        '{2'b00, 32'hffff_ffc0, 64'h0000_0000_0000_0001, 8'd1,  32'hffff_ffff},
        '{2'b01, 32'h0000_0080, 64'h5555_aaaa_5555_aaaa, 8'd255, 32'h0000_0080}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_dest(input logic [ADDR_W-1:0] a);
        return DW'((a >> LOFF) % NDIR);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 1'b0; rsp_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Present a request for one edge; returns at the falling edge after acceptance.
    task automatic send_req(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d, input logic [LEN_W-1:0] l);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_data = d; req_len = l;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Present a response for one edge; returns at the falling edge after it is consumed.
    task automatic send_rsp(input logic [1:0] k, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d);
        rsp_valid = 1'b1; rsp_kind = k; rsp_addr = a; rsp_data = d;
        @(posedge clk);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    // Called at the falling edge after acceptance; walks DLY further edges.
    task automatic watch_dir(input string tag, input logic wk, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, input logic [LEN_W-1:0] l);
        for (int j = 0; j <= DLY; j++) begin
            if (j == DLY - 1) begin
                chk({tag, " R3 dir_valid at delay"}, 64'(dir_valid), 64'd1);
                chk({tag, " R2 dir_kind"}, 64'(dir_kind), 64'(wk));
                chk({tag, " R2 dir_addr"}, 64'(dir_addr), 64'(a));
                chk({tag, " R2 dir_data"}, dir_data, d);
                chk({tag, " R2 dir_len"}, 64'(dir_len), 64'(l));
                chk({tag, " R4 dir_dest"}, 64'(dir_dest), 64'(exp_dest(a)));
            end else begin
                chk({tag, " R3 dir_valid off-slot"}, 64'(dir_valid), 64'd0);
            end
            if (j < DLY) @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        chk("R1 req_ready after reset", 64'(req_ready), 64'd1);
        chk("R1 dir_valid after reset", 64'(dir_valid), 64'd0);
        chk("R1 rd_valid after reset", 64'(rd_valid), 64'd0);
        chk("R1 wr_done after reset", 64'(wr_done), 64'd0);
        chk("R1 err_flag after reset", 64'(err_flag), 64'd0);

        // Table-driven transactions
        for (int v = 0; v < 4; v++) begin
            vec_t e;
            logic wr;
            e = VEC[v];
            wr = (e.kind == 2'b01);
            chk("R1 ready before txn", 64'(req_ready), 64'd1);
            send_req(e.kind, e.addr, e.data, e.len);
            chk("R5 ready low when busy", 64'(req_ready), 64'd0);
            watch_dir("vec", wr, e.addr, e.data, e.len);
            send_rsp(wr ? 2'b01 : 2'b10, e.raddr, ~e.data);
            chk(wr ? "R7 wr_done" : "R6 rd_valid", 64'(wr ? wr_done : rd_valid), 64'd1);
            chk(wr ? "R7 no rd_valid" : "R6 no wr_done", 64'(wr ? rd_valid : wr_done), 64'd0);
            if (!wr) chk("R6 rd_data", rd_data, ~e.data);
            chk("R8 cpl_addr aligned", 64'(cpl_addr), 64'(e.raddr & ~32'(63)));
            chk("R6 R7 back to ready", 64'(req_ready), 64'd1);
            @(negedge clk);
            chk("R6 R7 pulse single cycle", 64'(rd_valid | wr_done), 64'd0);
            chk("R12 no error on good txn", 64'(err_flag), 64'd0);
        end

        // R5: a second request held while busy
        req_valid = 1'b1; req_kind = 2'b00; req_addr = 32'h0000_0140;
        req_data = 64'h1111; req_len = 8'd8;
        @(posedge clk);
        @(negedge clk);
        req_kind = 2'b01; req_addr = 32'h0000_0300; req_data = 64'h2222; req_len = 8'd16;
        chk("R5 ready low with pending request", 64'(req_ready), 64'd0);
        watch_dir("R5 first", 1'b0, 32'h0000_0140, 64'h1111, 8'd8);
        chk("R5 held request not consumed", 64'(req_ready), 64'd0);
        send_rsp(2'b10, 32'h0000_0140, 64'h3333);
        chk("R5 ready after return", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 held store accepted", 64'(req_ready), 64'd0);
        watch_dir("R5 held", 1'b1, 32'h0000_0300, 64'h2222, 8'd16);
        send_rsp(2'b01, 32'h0000_0300, 64'h0);
        chk("R7 held store completes", 64'(wr_done), 64'd1);

        // R9: data in ST_BUSY_WR, then R12 stickiness
        send_req(2'b01, 32'h0000_0400, 64'h44, 8'd4);
        send_rsp(2'b10, 32'h0000_0400, 64'h55);
        chk("R9 err on data while writing", 64'(err_flag), 64'd1);
        chk("R9 no rd_valid on mismatch", 64'(rd_valid), 64'd0);
        chk("R9 still busy", 64'(req_ready), 64'd0);
        repeat (DLY) @(negedge clk);
        send_rsp(2'b01, 32'h0000_0400, 64'h0);
        chk("R9 ack still completes write", 64'(wr_done), 64'd1);
        repeat (4) @(negedge clk);
        chk("R12 err_flag sticky", 64'(err_flag), 64'd1);
        do_reset();
        chk("R12 reset clears err_flag", 64'(err_flag), 64'd0);

        // R9: ack in ST_BUSY_RD
        send_req(2'b00, 32'h0000_0500, 64'h66, 8'd4);
        repeat (DLY) @(negedge clk);
        send_rsp(2'b01, 32'h0000_0500, 64'h0);
        chk("R9 err on ack while reading", 64'(err_flag), 64'd1);
        chk("R9 no wr_done on mismatch", 64'(wr_done), 64'd0);
        chk("R9 read still pending", 64'(req_ready), 64'd0);
        send_rsp(2'b10, 32'h0000_0500, 64'h77);
        chk("R9 data completes read", 64'(rd_valid), 64'd1);
        do_reset();

        // R9: response in ST_READY
        send_rsp(2'b10, 32'h0000_0600, 64'h88);
        chk("R9 err on response in ready", 64'(err_flag), 64'd1);
        chk("R9 no rd_valid in ready", 64'(rd_valid), 64'd0);
        chk("R9 stays ready", 64'(req_ready), 64'd1);
        do_reset();

        // R10: illegal request codes
        send_req(2'b11, 32'h0000_0700, 64'h99, 8'd2);
        chk("R10 err on illegal request", 64'(err_flag), 64'd1);
        chk("R10 stays ready", 64'(req_ready), 64'd1);
        send_req(2'b10, 32'h0000_0740, 64'h9a, 8'd2);
        for (int j = 0; j <= DLY; j++) begin
            chk("R10 no message issued", 64'(dir_valid), 64'd0);
            @(negedge clk);
        end
        chk("R10 ready after illegal requests", 64'(req_ready), 64'd1);
        do_reset();

        // R11: illegal response code while reading
        send_req(2'b00, 32'h0000_0800, 64'hab, 8'd4);
        repeat (DLY) @(negedge clk);
        send_rsp(2'b11, 32'h0000_0800, 64'hcd);
        chk("R11 err on illegal response", 64'(err_flag), 64'd1);
        chk("R11 no completion", 64'(rd_valid | wr_done), 64'd0);
        chk("R11 still busy", 64'(req_ready), 64'd0);
        send_rsp(2'b00, 32'h0000_0800, 64'hcd);
        chk("R11 code 00 no completion", 64'(rd_valid | wr_done), 64'd0);
        send_rsp(2'b10, 32'h0000_0800, 64'hef);
        chk("R11 read completes afterwards", 64'(rd_valid), 64'd1);
        chk("R11 rd_data", rd_data, 64'hef);
        do_reset();

        // R13: early response leaves message in pipeline
        send_req(2'b00, 32'h0000_0900, 64'h12, 8'd4);
        send_rsp(2'b10, 32'h0000_0900, 64'h34);
        chk("R13 early data completes", 64'(rd_valid), 64'd1);
        for (int j = 1; j <= DLY; j++) begin
            chk("R13 dir_valid timing", 64'(dir_valid), 64'(j == DLY - 1));
            chk("R13 ready waits for pipeline", 64'(req_ready), 64'(j >= DLY));
            if (j < DLY) @(negedge clk);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule